// File: doc/BRIEF.md
# Trimmed Real-Time-Clock Predivider

This block turns a nominal 32.768 kHz input clock into a one-second tick and keeps a running count of seconds. A down-counting predivider is reloaded on every underflow. Most reloads use the fixed value that gives an exact 32768-clock second. Once in every 64 seconds the reload uses a programmable trim value instead. That single longer or shorter second corrects slow drift in the oscillator while leaving the normal divide ratio unchanged.

Software sets the trim value through a small synchronous register port. One 32-bit word holds a 16-bit trim field, and the rest of the word is fixed at zero. A new trim value is picked up at the next trimmed reload only, so a write never cuts short a second that has already started. The block emits a one-cycle tick at every underflow and advances its seconds counter on the same edge.

Top module: `rtc_trim_div`

## Requirements
- R1: While reset is asserted and right after it, `sec_tick` is 0 and `seconds` is 0. The trim field reads back as the default reload 2^PRE_W-1 (0x7FFF with default parameters).
- R2: Each untrimmed second lasts exactly 2^PRE_W input clocks, measured from one `sec_tick` pulse to the next. Every `sec_tick` pulse is one clock wide.
- R3: The second that starts at the tick where `seconds` becomes a multiple of 2^PERIOD_LOG2 (64) is loaded from the trim field. It lasts trim+1 clocks, using the trim value held just before that tick.
- R4: Any 64-second trim period, taken from one such tick to the next, lasts 64*2^PRE_W + (trim - (2^PRE_W-1)) input clocks. A trim above the default slows the clock and a trim below it speeds the clock up.
- R5: `seconds` goes up by exactly one on each clock where `sec_tick` is 1, is otherwise unchanged, and wraps modulo 2^SEC_W.
- R6: A trim write made during a second that is already counting leaves that second's length unchanged. The new value is used only at the next trimmed reload.
- R7: A write with `reg_valid`=1 and `reg_we`=1 at byte offset 0x24 stores `reg_wdata[15:0]` as the trim. Bits 31:16 are ignored on write and read back as zero.
- R8: Reads from any offset other than 0x24 return zero. Writes to other offsets do not change the trim field.
- R9: Read data appears on `reg_rdata` one clock after a request with `reg_valid`=1 and `reg_we`=0. On all other clocks `reg_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nominal 32.768 kHz counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after the request |
| sec_tick | output | 1 | One-clock pulse at every predivider underflow |
| seconds | output | SEC_W | Running count of elapsed seconds |

## Verification
The assertions assume the trim field is never zero. With a zero trim the trimmed second would last a single clock, and two ticks would fall on back-to-back clocks. They also assume the register port is idle during reset. The stimulus only ever writes trim values within a few dozen clocks of the default, and sometimes one large value that is overwritten well before a trimmed reload. It drives the register inputs low for the whole reset phase. Writes land at random clocks, including clocks inside a trimmed second and clocks that fall on a tick edge.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
   localparam int WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
   import rtc_trim_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int TRIM_W = 16,
   parameter logic [TRIM_W-1:0] TRIM_RESET = '1,
   parameter logic [ADDR_W-1:0] TRIM_OFS = 8'h24
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  word_t             wdata,
   output word_t             rdata,
   output logic [TRIM_W-1:0] trim
);
   if (TRIM_W > WORD_W || TRIM_W < 2) begin : g_bad_width
      $error("rtc_trim_regs: TRIM_W must be between 2 and the word width");
   end
   if (TRIM_OFS[1:0] != 2'b00) begin : g_bad_ofs
      $error("rtc_trim_regs: TRIM_OFS must be word aligned");
   end

   logic [TRIM_W-1:0] trim_q;
   word_t             rdata_q;
   word_t             field_rd;
   logic              hit;

   assign hit = valid && (addr == TRIM_OFS);

   if (TRIM_W == WORD_W) begin : g_full
      assign field_rd = trim_q;
   end else begin : g_ext
      assign field_rd = {{(WORD_W-TRIM_W){1'b0}}, trim_q};
      logic unused_hi;
      assign unused_hi = ^wdata[WORD_W-1:TRIM_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trim_q  <= TRIM_RESET;
         rdata_q <= '0;
      end else begin
         if (hit && we) trim_q <= wdata[TRIM_W-1:0];
         rdata_q <= (hit && !we) ? field_rd : '0;
      end
   end

   assign rdata = rdata_q;
   assign trim  = trim_q;
endmodule

// File: rtl/rtc_trim_prediv.sv
module rtc_trim_prediv #(
   parameter int TRIM_W = 16,
   parameter logic [TRIM_W-1:0] DEF_RELOAD = '1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRIM_W-1:0] trim,
   input  logic              use_trim,
   output logic              wrap
);
   logic [TRIM_W-1:0] cnt_q;

   assign wrap = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= DEF_RELOAD;
      else if (wrap) cnt_q <= use_trim ? trim : DEF_RELOAD;
      else           cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/rtc_trim_seconds.sv
module rtc_trim_seconds #(
   parameter int SEC_W = 32,
   parameter int PERIOD_LOG2 = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap,
   output logic [SEC_W-1:0] seconds,
   output logic             tick,
   output logic             period_last
);
   if (PERIOD_LOG2 < 1) begin : g_bad_period
      $error("rtc_trim_seconds: PERIOD_LOG2 must be at least 1");
   end

   logic [SEC_W-1:0] sec_q;
   logic             tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= wrap;
         if (wrap) sec_q <= sec_q + 1'b1;
      end
   end

   if (SEC_W >= PERIOD_LOG2) begin : g_shared
      assign period_last = &sec_q[PERIOD_LOG2-1:0];
   end else begin : g_own
      logic [PERIOD_LOG2-1:0] per_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    per_q <= '0;
         else if (wrap) per_q <= per_q + 1'b1;
      end
      assign period_last = &per_q;
   end

   assign seconds = sec_q;
   assign tick    = tick_q;
endmodule

// File: rtl/rtc_trim_div.sv
module rtc_trim_div
   import rtc_trim_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PRE_W = 15,
   parameter int TRIM_W = 16,
   parameter int SEC_W = 32,
   parameter int PERIOD_LOG2 = 6,
   parameter logic [ADDR_W-1:0] TRIM_OFS = 8'h24
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              sec_tick,
   output logic [SEC_W-1:0]  seconds
);
   localparam logic [TRIM_W-1:0] DEF_RELOAD = TRIM_W'((64'd1 << PRE_W) - 1);

   if (PRE_W + 1 > TRIM_W) begin : g_bad_pre
      $error("rtc_trim_div: TRIM_W must exceed PRE_W so the trim can lengthen a second");
   end
   if (SEC_W < 1 || SEC_W > 64) begin : g_bad_sec
      $error("rtc_trim_div: SEC_W out of range");
   end

   logic [TRIM_W-1:0] trim;
   logic              wrap;
   logic              period_last;

   rtc_trim_regs #(
      .ADDR_W(ADDR_W), .TRIM_W(TRIM_W),
      .TRIM_RESET(DEF_RELOAD), .TRIM_OFS(TRIM_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .valid(reg_valid), .we(reg_we),
      .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .trim(trim)
   );

   rtc_trim_prediv #(.TRIM_W(TRIM_W), .DEF_RELOAD(DEF_RELOAD)) u_prediv (
      .clk(clk), .rst_n(rst_n), .trim(trim), .use_trim(period_last), .wrap(wrap)
   );

   rtc_trim_seconds #(.SEC_W(SEC_W), .PERIOD_LOG2(PERIOD_LOG2)) u_secs (
      .clk(clk), .rst_n(rst_n), .wrap(wrap),
      .seconds(seconds), .tick(sec_tick), .period_last(period_last)
   );
endmodule

// File: rtl/rtc_trim_div_chk.sv
module rtc_trim_div_chk #(
   parameter int ADDR_W = 8,
   parameter int TRIM_W = 16,
   parameter int SEC_W = 32,
   parameter logic [ADDR_W-1:0] TRIM_OFS = 8'h24
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_valid,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic              sec_tick,
   input logic [SEC_W-1:0]  seconds
);
   logic [TRIM_W:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        gap_q <= '0;
      else if (sec_tick) gap_q <= '0;
      else               gap_q <= gap_q + 1'b1;
   end

   assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   assert_gap_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= (TRIM_W+1)'(1 << TRIM_W));

   assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> seconds == $past(seconds) + 1'b1);

   assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick |-> $stable(seconds));

   assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[31:16] == 16'h0);

   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_we && reg_addr != TRIM_OFS) |=> reg_rdata == 32'h0);

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_valid && !reg_we) |=> reg_rdata == 32'h0);
endmodule

bind rtc_trim_div rtc_trim_div_chk #(
   .ADDR_W(ADDR_W), .TRIM_W(TRIM_W), .SEC_W(SEC_W), .TRIM_OFS(TRIM_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata), .sec_tick(sec_tick), .seconds(seconds)
);

// File: tb/sim_rtc_trim_div.sv
`timescale 1ns/1ps
module sim_rtc_trim_div;
   localparam int PRE_W = 6;
   localparam int SEC_W = 8;
   localparam int DEF = (1 << PRE_W) - 1;
   localparam int PER = 64;
   localparam int MAXN = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sec_tick;
   logic [SEC_W-1:0] seconds;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int n_ticks = 0;
   int shadow = DEF;
   int trim_prev = DEF;
   bit prev_tick = 1'b0;
   bit double_tick = 1'b0;
   int time_at [MAXN];
   int trim_at [MAXN];
   int sec_at  [MAXN];

   always #4 clk = ~clk;

   rtc_trim_div #(.PRE_W(PRE_W), .TRIM_W(16), .SEC_W(SEC_W), .PERIOD_LOG2(6)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sec_tick(sec_tick), .seconds(seconds)
   );

   // reference model of the trim field, from R7/R8
   always @(posedge clk) begin
      cyc <= cyc + 1;
      trim_prev <= shadow;
      if (!rst_n) shadow <= DEF;
      else if (reg_valid && reg_we && reg_addr == 8'h24) shadow <= int'(reg_wdata[15:0]);
   end

   always @(negedge clk) begin
      if (rst_n && sec_tick) begin
         if (prev_tick) double_tick = 1'b1;
         n_ticks = n_ticks + 1;
         if (n_ticks < MAXN) begin
            time_at[n_ticks] = cyc;
            trim_at[n_ticks] = trim_prev;
            sec_at[n_ticks]  = int'(seconds);
         end
      end
      prev_tick = sec_tick;
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_we = 1'b0; reg_addr = a;
      @(negedge clk);
      reg_valid = 1'b0;
      d = reg_rdata;
   endtask

   function automatic int sec_len(input int n);
      return ((n - 1) % PER == 0) ? trim_at[n-1] + 1 : DEF + 1;
   endfunction

   function automatic int period_len(input int n0);
      return PER * (DEF + 1) + (trim_at[n0] - DEF);
   endfunction

   task automatic run_main();
      logic [31:0] rd;
      int t2;
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      chk("R1", "tick in reset", sec_tick, 0);
      chk("R1", "seconds in reset", seconds, 0);
      @(negedge clk); rst_n = 1'b1;
      chk("R1", "seconds after reset", seconds, 0);
      reg_read(8'h24, rd);
      chk("R1", "trim reset value", rd, DEF);
      @(negedge clk);
      chk("R9", "rdata idle", rd === reg_rdata ? 0 : reg_rdata, 0);
      reg_write(8'h24, 32'hABCD_1234);
      reg_read(8'h24, rd);
      chk("R7", "upper bits dropped", rd, 32'h0000_1234);
      reg_write(8'h20, 32'h0000_0011);
      reg_write(8'h28, 32'h0000_0022);
      reg_read(8'h24, rd);
      chk("R8", "trim after foreign writes", rd, 32'h1234);
      reg_read(8'h28, rd);
      chk("R8", "unmapped read", rd, 0);
      @(negedge clk);
      chk("R9", "rdata idle after read", reg_rdata, 0);
      reg_write(8'h24, 32'(DEF));
      wait (n_ticks >= 70);
      reg_write(8'h24, 32'(DEF + int'($urandom_range(1, 40))));
      wait (n_ticks >= 130);
      t2 = DEF - int'($urandom_range(1, 40));
      reg_write(8'h24, {16'hFFFF, 16'(t2)});
      wait (n_ticks >= 192);
      repeat (5) @(negedge clk);
      reg_write(8'h24, 32'(DEF + int'($urandom_range(1, 40))));
      wait (n_ticks >= 194);
      chk("R6", "second in progress kept old trim", time_at[193] - time_at[192], t2 + 1);
      while (n_ticks < 300) begin
         repeat (int'($urandom_range(1, 500))) @(negedge clk);
         if (int'($urandom_range(0, 1)) == 1)
            reg_write(8'h24, {16'($urandom), 16'(DEF + int'($urandom_range(1, 40)))});
         else
            reg_write(8'h24, {16'($urandom), 16'(DEF - int'($urandom_range(1, 40)))});
      end
      for (int n = 2; n <= 300; n++)
         chk(((n - 1) % PER == 0) ? "R3" : "R2", $sformatf("length of second %0d", n),
             time_at[n] - time_at[n-1], sec_len(n));
      for (int m = 1; (m + 1) * PER <= 300; m++)
         chk("R4", $sformatf("period %0d clocks", m),
             time_at[(m+1)*PER] - time_at[m*PER], period_len(m * PER));
      for (int n = 1; n <= 300; n++)
         chk("R5", $sformatf("seconds at tick %0d", n), sec_at[n], n % (1 << SEC_W));
      chk("R2", "tick pulse width", double_tick, 0);
   endtask

   initial begin
      fork
         run_main();
         begin
            repeat (60000) @(posedge clk);
            checks++; errors++;
            $display("FAIL R2 watchdog: actual=%0d ticks expected=300", n_ticks);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule